// File: doc/BRIEF.md
# Parallel Byte Configuration Host

This block is the host side of a byte-wide configuration load. A start request makes it pull its active-low program output low for a programmed number of system clocks and then release it. It then waits for the target to signal readiness on its active-low status input. After that it takes bitstream bytes from an upstream valid/ready stream, puts each byte on an 8-bit bus, and toggles a byte clock at half the system clock rate. The target samples the bus on the rising edge of that clock.

Two pacings are supported, and the choice is captured when the start request is taken. Normal pacing gives one rising edge per byte. Slow pacing, used for compressed or encrypted bitstreams, holds each byte across four rising edges. The target raises its finish flag one byte before the stream ends, so the host keeps going until the marked last byte has been clocked. It then gives at least three further clock edges and only then reports success. The finish flag only counts on a low-to-high transition. If the status input drops during a transfer, the host stops and reports an error. It also reports an error if the finish transition never comes within a bounded number of trailing edges. A new start request restarts the whole sequence.

Top module: `pbcfg_host`

## Requirements
- R1: While reset is asserted, and right after it, `prog_n_o` is high, `bclk_o` is low, and `s_ready_o`, `busy_o`, `ok_o` and `err_o` are all low.
- R2: A start request in the idle, success or error state drives `prog_n_o` low for exactly RST_CYCLES (default 8) system clocks. After that it returns high.
- R3: While the synchronised target status input `tgt_rdy_i` is low before a transfer, `bclk_o` never rises and `s_ready_o` stays low.
- R4: In normal pacing, each accepted byte is given exactly one rising edge of `bclk_o`, in stream order. `bdat_o` changes only while `bclk_o` is low, so the bus is stable whenever the clock is high.
- R5: In slow pacing (`slow_i` high at start), each byte is held on `bdat_o` across exactly SLOW_EDGES (default 4) consecutive rising edges of `bclk_o`.
- R6: `bclk_o` is a divide-by-two of the system clock. It is never high for two system clocks in a row.
- R7: A rise of `tgt_fin_i` before the last byte does not stop the transfer. Every byte up to the one marked by `s_last_i` is still clocked out.
- R8: After the last byte's final edge, at least FLUSH_EDGES (default 3) more rising edges are given. With the finish transition already seen, exactly FLUSH_EDGES are given. Then `ok_o` rises and `bclk_o` stays low.
- R9: If no low-to-high transition of `tgt_fin_i` is seen during the transfer (including the case where the input stays high throughout), `err_o` rises. This happens after exactly TIMEOUT_EDGES (default 64) trailing rising edges.
- R10: If `tgt_rdy_i` falls during a transfer, `err_o` rises within a few clocks. From then on `bclk_o` stays low and `s_ready_o` stays low until a new start request.
- R11: A start request during a transfer is ignored (`prog_n_o` stays high). `ok_o` or `err_o` holds until the next start request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one clock wide |
| slow_i | input | 1 | Slow pacing select, captured at start |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | 8 | Upstream byte |
| s_last_i | input | 1 | Marks the final bitstream byte |
| s_ready_o | output | 1 | Byte accepted when high with valid |
| prog_n_o | output | 1 | Active-low program request to the target |
| tgt_rdy_i | input | 1 | Target status, low while the target is in reset or in error |
| tgt_fin_i | input | 1 | Target finish flag |
| bclk_o | output | 1 | Byte clock to the target |
| bdat_o | output | 8 | Byte bus to the target |
| busy_o | output | 1 | A load sequence is in progress |
| ok_o | output | 1 | Load completed |
| err_o | output | 1 | Load failed |

## Verification
The bench models the target. It counts rising edges of the byte clock and latches bytes on them, and it raises the finish flag right after the next-to-last byte. So a host that stopped at the finish edge would lose the last byte, and one that cut the flush short would show fewer than three trailing edges. In slow pacing the bench compares the byte across all four edges. A host that advanced early would show up as a group mismatch and a wrong total edge count. Three further cases target error handling:
- A finish flag held high from the start checks that only a transition counts; a level-sensitive host would report success instead of timing out.
- A status drop in mid-stream must freeze the clock.
- A start pulse in mid-stream must not re-pulse the program line.

// File: rtl/pbcfg_pkg.sv
package pbcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RESET = 3'd1,
        ST_WAIT  = 3'd2,
        ST_XFER  = 3'd3,
        ST_FLUSH = 3'd4,
        ST_OK    = 3'd5,
        ST_ERR   = 3'd6
    } host_state_e;

endpackage

// File: rtl/pbcfg_sync.sv
module pbcfg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;
    logic [STAGES-1:0][W-1:0] stg_d;

    if (STAGES == 1) begin : g_single
        always_comb stg_d = d;
    end else begin : g_chain
        always_comb stg_d = {stg_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pbcfg_count.sv
module pbcfg_count #(
    parameter int W   = 8,
    parameter int MAX = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val
);

    localparam logic [W-1:0] TOP = W'(MAX);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr)                     val_d = '0;
        else if (inc && val_q != TOP) val_d = val_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;

endmodule

// File: rtl/pbcfg_host.sv
module pbcfg_host
    import pbcfg_pkg::*;
#(
    parameter int DW            = 8,
    parameter int RST_CYCLES    = 8,
    parameter int SLOW_EDGES    = 4,
    parameter int FLUSH_EDGES   = 3,
    parameter int TIMEOUT_EDGES = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          slow_i,
    input  logic          s_valid_i,
    input  logic [DW-1:0] s_data_i,
    input  logic          s_last_i,
    output logic          s_ready_o,
    output logic          prog_n_o,
    input  logic          tgt_rdy_i,
    input  logic          tgt_fin_i,
    output logic          bclk_o,
    output logic [DW-1:0] bdat_o,
    output logic          busy_o,
    output logic          ok_o,
    output logic          err_o
);

    localparam int CNT_MAX = (RST_CYCLES > TIMEOUT_EDGES) ? RST_CYCLES : TIMEOUT_EDGES;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int RW      = $clog2(SLOW_EDGES + 1);

    localparam logic [RW-1:0] HOLD_SLOW = RW'(SLOW_EDGES);
    localparam logic [RW-1:0] HOLD_ONE  = RW'(1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] FLUSH_MIN = CW'(FLUSH_EDGES);
    localparam logic [CW-1:0] TMO_LIM   = CW'(TIMEOUT_EDGES);

    typedef struct packed {
        host_state_e   st;
        logic          bclk;
        logic [DW-1:0] dat;
        logic [RW-1:0] rem;
        logic          last;
        logic          slow;
        logic          fin_prev;
        logic          fin_seen;
    } host_regs_t;

    host_regs_t    r_d, r_q;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    logic [1:0]    sync_q;
    logic          rdy_s, fin_s;
    logic          fin_rise, fin_any;

    pbcfg_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tgt_rdy_i, tgt_fin_i}),
        .q     (sync_q)
    );

    assign rdy_s = sync_q[1];
    assign fin_s = sync_q[0];

    pbcfg_count #(
        .W   (CW),
        .MAX (CNT_MAX)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .val   (cnt)
    );

    assign fin_rise  = fin_s && !r_q.fin_prev;
    assign fin_any   = r_q.fin_seen || fin_rise;
    assign s_ready_o = (r_q.st == ST_XFER) && rdy_s && (r_q.rem == '0) && !r_q.last;

    always_comb begin
        r_d          = r_q;
        cnt_clr      = 1'b0;
        cnt_inc      = 1'b0;
        r_d.fin_prev = fin_s;
        case (r_q.st)
            ST_IDLE, ST_OK, ST_ERR: begin
                r_d.bclk = 1'b0;
                if (start_i) begin
                    r_d.st   = ST_RESET;
                    r_d.slow = slow_i;
                    cnt_clr  = 1'b1;
                end
            end
            ST_RESET: begin
                if (cnt == RST_LAST) r_d.st = ST_WAIT;
                else                 cnt_inc = 1'b1;
            end
            ST_WAIT: begin
                if (rdy_s) begin
                    r_d.st       = ST_XFER;
                    r_d.rem      = '0;
                    r_d.last     = 1'b0;
                    r_d.fin_seen = 1'b0;
                    r_d.bclk     = 1'b0;
                end
            end
            ST_XFER: begin
                r_d.fin_seen = fin_any;
                if (!rdy_s) begin
                    r_d.st   = ST_ERR;
                    r_d.bclk = 1'b0;
                end else begin
                    if (r_q.bclk) begin
                        r_d.bclk = 1'b0;
                        if (r_q.rem == '0 && r_q.last) begin
                            r_d.st  = ST_FLUSH;
                            cnt_clr = 1'b1;
                        end
                    end else if (r_q.rem != '0) begin
                        r_d.bclk = 1'b1;
                        r_d.rem  = r_q.rem - RW'(1);
                    end
                    if (s_ready_o && s_valid_i) begin
                        r_d.dat  = s_data_i;
                        r_d.rem  = r_q.slow ? HOLD_SLOW : HOLD_ONE;
                        r_d.last = s_last_i;
                    end
                end
            end
            ST_FLUSH: begin
                r_d.fin_seen = fin_any;
                if (!rdy_s) begin
                    r_d.st   = ST_ERR;
                    r_d.bclk = 1'b0;
                end else if (r_q.bclk) begin
                    r_d.bclk = 1'b0;
                end else if (fin_any && cnt >= FLUSH_MIN) begin
                    r_d.st = ST_OK;
                end else if (cnt >= TMO_LIM) begin
                    r_d.st = ST_ERR;
                end else begin
                    r_d.bclk = 1'b1;
                    cnt_inc  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign prog_n_o = (r_q.st != ST_RESET);
    assign bclk_o   = r_q.bclk;
    assign bdat_o   = r_q.dat;
    assign busy_o   = (r_q.st == ST_RESET) || (r_q.st == ST_WAIT) ||
                      (r_q.st == ST_XFER)  || (r_q.st == ST_FLUSH);
    assign ok_o     = (r_q.st == ST_OK);
    assign err_o    = (r_q.st == ST_ERR);

    // R6
    bclk_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bclk |=> !r_q.bclk);

    // R4
    bdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.dat) |-> !r_q.bclk);

    // R3
    edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.bclk) |-> $past(rdy_s));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ERR) |=> !r_q.bclk);

    // R8
    ok_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> ($past(cnt) >= FLUSH_MIN));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_XFER || r_q.st == ST_FLUSH) && start_i) |=> prog_n_o);

endmodule

// File: tb/test_pbcfg_host.sv
module test_pbcfg_host;

    localparam int RST   = 8;
    localparam int SLOW  = 4;
    localparam int FLUSH = 3;
    localparam int TMO   = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       slow = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_last = 1'b0;
    logic       tgt_rdy = 1'b0;
    logic       tgt_fin = 1'b0;
    logic       s_ready_o, prog_n_o, bclk_o, busy_o, ok_o, err_o;
    logic [7:0] bdat_o;

    always #4 clk = ~clk;

    pbcfg_host i_pbcfg_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .slow_i    (slow),
        .s_valid_i (s_valid),
        .s_data_i  (s_data),
        .s_last_i  (s_last),
        .s_ready_o (s_ready_o),
        .prog_n_o  (prog_n_o),
        .tgt_rdy_i (tgt_rdy),
        .tgt_fin_i (tgt_fin),
        .bclk_o    (bclk_o),
        .bdat_o    (bdat_o),
        .busy_o    (busy_o),
        .ok_o      (ok_o),
        .err_o     (err_o)
    );

    int checks = 0;
    int fails  = 0;

    int nbytes = 0, lat_cnt = 0, trailing = 0, rises = 0;
    int grp_pos = 0, grp_bad = 0, pre_viol = 0, prog_low_xfer = 0;
    int bclk_wide = 0, dat_glitch = 0;
    bit cur_slow = 0, pre_status = 0, xfer_phase = 0, auto_fin = 0;
    bit prev_bclk = 0;
    logic [7:0] prev_dat = 8'h00, grp_first = 8'h00;
    logic [7:0] rx [64];
    logic [7:0] ex [64];

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rises(input int n, input bit sl);
        return n * (sl ? SLOW : 1) + FLUSH;
    endfunction

    task automatic take_byte();
        rx[lat_cnt] = bdat_o;
        lat_cnt++;
        if (auto_fin && lat_cnt == nbytes - 1) tgt_fin = 1'b1;
    endtask

    // target model and line monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (bclk_o && prev_bclk) bclk_wide++;
            if (bclk_o && bdat_o != prev_dat) dat_glitch++;
            if (pre_status && (bclk_o || s_ready_o)) pre_viol++;
            if (xfer_phase && !prog_n_o) prog_low_xfer++;
            if (bclk_o && !prev_bclk) begin
                rises++;
                if (lat_cnt >= nbytes) trailing++;
                else if (cur_slow) begin
                    if (grp_pos == 0) grp_first = bdat_o;
                    else if (bdat_o != grp_first) grp_bad++;
                    if (grp_pos == SLOW - 1) begin
                        grp_pos = 0;
                        take_byte();
                    end else grp_pos++;
                end else take_byte();
            end
            prev_bclk = bclk_o;
            prev_dat  = bdat_o;
        end
    end

    task automatic run_cfg(input int n, input bit sl, input int gap, input bit stuck,
                           input int drop_at, input bit mid_start);
        int lowc, idx, guard, w, r0, bad;
        bit fire, ms_done;
        nbytes = n; cur_slow = sl; lat_cnt = 0; trailing = 0; grp_pos = 0;
        grp_bad = 0; rises = 0; pre_viol = 0; prog_low_xfer = 0;
        for (int i = 0; i < n; i++) ex[i] = 8'($urandom);
        auto_fin = !stuck; tgt_fin = stuck; tgt_rdy = 1'b0; slow = sl;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lowc = 0;
        while (!prog_n_o && lowc < 1000) begin
            lowc++;
            @(negedge clk);
        end
        chk_eq("R2 program pulse width", lowc, RST);
        pre_status = 1'b1;
        repeat ($urandom_range(3, 10)) @(negedge clk);
        tgt_rdy = 1'b1; pre_status = 1'b0; xfer_phase = 1'b1;
        idx = 0; guard = 0; fire = 0; ms_done = 0;
        while (idx < n && !err_o && guard < 20000) begin
            @(negedge clk);
            guard++;
            start = 1'b0;
            if (fire) begin
                idx++;
                s_valid = 1'b0;
            end
            if (drop_at >= 0 && idx == drop_at) begin
                tgt_rdy = 1'b0; s_valid = 1'b0; fire = 0;
                break;
            end
            if (mid_start && !ms_done && idx == n / 2) begin
                start = 1'b1; ms_done = 1;
            end
            if (idx < n && !s_valid && $urandom_range(99) >= gap) begin
                s_valid = 1'b1; s_data = ex[idx]; s_last = (idx == n - 1);
            end
            fire = s_valid && s_ready_o;
        end
        start = 1'b0; s_valid = 1'b0;
        w = 0;
        while (!ok_o && !err_o && w < 2000) begin
            @(negedge clk);
            w++;
        end
        xfer_phase = 1'b0;
        if (drop_at >= 0) begin
            chk_eq("R10 error after status drop", int'(err_o), 1);
            r0 = rises;
            repeat (20) @(negedge clk);
            chk_eq("R10 clock frozen after drop", rises - r0, 0);
            chk_eq("R10 ready low after drop", int'(s_ready_o), 0);
        end else if (stuck) begin
            chk_eq("R9 timeout error", int'(err_o), 1);
            chk_eq("R9 trailing edges before timeout", trailing, TMO);
            chk_eq("R9 ok stays low", int'(ok_o), 0);
            chk_eq("R7 bytes clocked", lat_cnt, n);
        end else begin
            chk_eq("R8 success flag", int'(ok_o), 1);
            chk_eq("R8 trailing flush edges", trailing, FLUSH);
            chk_eq("R7 all bytes clocked past finish", lat_cnt, n);
            bad = 0;
            for (int i = 0; i < n; i++) if (rx[i] != ex[i]) bad++;
            chk_eq(sl ? "R5 byte order" : "R4 byte order", bad, 0);
            chk_eq(sl ? "R5 total edges" : "R4 total edges", rises, exp_rises(n, sl));
            if (sl) chk_eq("R5 byte held over group", grp_bad, 0);
            r0 = rises;
            repeat (30) @(negedge clk);
            chk_eq("R8 clock idle after success", rises - r0, 0);
            chk_eq("R11 success held", int'(ok_o), 1);
        end
        chk_eq("R3 no clock or ready before status", pre_viol, 0);
        if (mid_start) chk_eq("R11 start ignored while busy", prog_low_xfer, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk_eq("R1 program high in reset", int'(prog_n_o), 1);
        chk_eq("R1 clock low in reset", int'(bclk_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 ready low", int'(s_ready_o), 0);
        chk_eq("R1 busy low", int'(busy_o), 0);
        chk_eq("R1 ok low", int'(ok_o), 0);
        chk_eq("R1 err low", int'(err_o), 0);
        chk_eq("R1 program high", int'(prog_n_o), 1);

        run_cfg(2, 0, 0, 0, -1, 0);
        run_cfg(20, 0, 40, 0, -1, 0);
        run_cfg(6, 1, 0, 0, -1, 0);
        run_cfg(10, 1, 30, 0, -1, 1);
        run_cfg(5, 0, 0, 1, -1, 0);
        run_cfg(8, 0, 20, 0, -1, 0);
        run_cfg(16, 0, 10, 0, 6, 0);
        run_cfg(4, 1, 0, 0, -1, 0);
        for (int k = 0; k < 6; k++)
            run_cfg($urandom_range(2, 24), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 60), 0, -1, 0);

        chk_eq("R6 clock never high two cycles", bclk_wide, 0);
        chk_eq("R4 bus stable while clock high", dat_glitch, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule